// File: doc/BRIEF.md
# Segmented Memory Bus Interface

This block sits between an execution core and byte-addressed memory. It forms 20-bit physical byte addresses by shifting a 16-bit segment value left by four bits and adding a 16-bit offset. It then moves bytes or words over a 16-bit data bus that has one byte lane per half. The block holds the code, data and stack segment registers, the instruction pointer and the stack pointer.

A request carries one of four access kinds: instruction fetch, data access, push or pop. The block picks the segment and the offset that belong to that kind. It runs one bus cycle, or two bus cycles when a word starts at an odd address, and returns a single response. A fetch advances the instruction pointer. A push moves the stack pointer down before it writes, and a pop moves the stack pointer up after it reads.

Top module: `segbus_unit`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. A carry out of bit 19 is dropped, so segment 0xFFFF with offset 0x0010 gives address 0x00000.
- R2: `req_kind` is encoded 0 = fetch, 1 = data, 2 = push, 3 = pop. Each kind uses its own segment and offset:
  - fetch uses the code segment with the instruction pointer;
  - data uses the data segment with `req_ea`;
  - push and pop use the stack segment with the stack pointer.
- R3: Lane rules:
  - `mem_addr` is the byte address of the first byte moved in the current bus cycle.
  - A byte at an even address travels on bits 7:0 with `mem_be` = 01.
  - A byte at an odd address travels on bits 15:8 with `mem_be` = 10.
  - `mem_be` bit 0 marks the low lane and bit 1 marks the high lane. Only the lanes that carry data are enabled.
- R4: A word at an even address takes one bus cycle with `mem_be` = 11. Its low byte sits at the lower address, on bits 7:0.
- R5: A word at an odd address A takes two bus cycles:
  - the first at A with `mem_be` = 10, moving the low byte on bits 15:8;
  - the second at A+1 with `mem_be` = 01, moving the high byte on bits 7:0.
  
  For a read, both bytes are joined into one word before the response.
- R6: Stack accesses are always words.
  - A push first lowers the stack pointer by 2, then writes `req_wdata` at the new stack pointer.
  - A pop reads at the current stack pointer, then raises it by 2 when the read completes.
- R7: A completed fetch advances the instruction pointer by 1 for a byte fetch and by 2 for a word fetch (`req_word` = 1).
- R8: Handshake:
  - A request is taken in a cycle where `req_valid` and `req_ready` are both high.
  - `req_ready` then stays low until the transfer ends.
  - `resp_valid` is high for exactly one cycle, in the cycle after the final `mem_ack`.
  - `resp_rdata` holds the read word, or the byte zero-extended. It is zero for writes.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold steady. `mem_req` is low whenever the block is idle.
- R10: Register loads:
  - `reg_wr_sel` is encoded 0 = code segment, 1 = data segment, 2 = stack segment, 3 = instruction pointer, 4 = stack pointer.
  - A load takes effect only in a cycle where the block is idle and `req_valid` is low. A load at any other time is ignored.
  - After reset every register is zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Load a segment or pointer register |
| reg_wr_sel | input | 3 | Register to load (R10 encoding) |
| reg_wr_val | input | 16 | Value to load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | Access kind (R2 encoding) |
| req_write | input | 1 | Data access is a write |
| req_word | input | 1 | Access is a word (otherwise a byte) |
| req_ea | input | 16 | Effective address for data access |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| resp_valid | output | 1 | Transfer finished |
| resp_rdata | output | 16 | Read result |
| mem_req | output | 1 | Bus cycle request |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Bus cycle writes |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data from memory |
| mem_ack | input | 1 | Bus cycle done |

## Verification
A wrong stack or instruction pointer stays hidden until the next access of the same kind. That access then shows up on `mem_addr`, so the bench chains a push with a pop and a second push, and chains fetches one after another. A bad misaligned-word split shows on the same transfer: it appears as a wrong lane enable or address in the first or second bus cycle, or as swapped bytes in `resp_rdata`. A register load that should have been ignored is exposed by the address of the very next data access.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_DATA  = 2'd1,
        K_PUSH  = 2'd2,
        K_POP   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } bus_st_e;

    localparam logic [2:0] SEL_CODE  = 3'd0;
    localparam logic [2:0] SEL_DATA  = 3'd1;
    localparam logic [2:0] SEL_STACK = 3'd2;
    localparam logic [2:0] SEL_IP    = 3'd3;
    localparam logic [2:0] SEL_SP    = 3'd4;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg,
    input  logic [OFS_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ext_off;

    always_comb begin
        base    = {seg, {SEG_SHIFT{1'b0}}};
        ext_off = PA_W'(off);
        phys    = base + ext_off;   // modulo 2^PA_W
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
    parameter int LANE_W  = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              start_odd,
    input  logic              word,
    input  logic              second,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [LANE_W-1:0] lo_hold,
    output logic [1:0]        be,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LANE_W-1:0] lo_capture,
    output logic [DATA_W-1:0] final_rdata
);
    logic [LANE_W-1:0] w_lo, w_hi, r_lo, r_hi;
    localparam logic [LANE_W-1:0] ZB = '0;

    always_comb begin
        w_lo        = wdata[LANE_W-1:0];
        w_hi        = wdata[DATA_W-1:LANE_W];
        r_lo        = bus_rdata[LANE_W-1:0];
        r_hi        = bus_rdata[DATA_W-1:LANE_W];
        lo_capture  = r_hi;
        be          = 2'b00;
        bus_wdata   = '0;
        final_rdata = '0;
        if (!word) begin
            if (start_odd) begin
                be          = 2'b10;
                bus_wdata   = {w_lo, ZB};
                final_rdata = {ZB, r_hi};
            end else begin
                be          = 2'b01;
                bus_wdata   = {ZB, w_lo};
                final_rdata = {ZB, r_lo};
            end
        end else if (!start_odd) begin
            be          = 2'b11;
            bus_wdata   = wdata;
            final_rdata = bus_rdata;
        end else if (!second) begin
            be          = 2'b10;
            bus_wdata   = {w_lo, ZB};
            final_rdata = {ZB, r_hi};
        end else begin
            be          = 2'b01;
            bus_wdata   = {ZB, w_hi};
            final_rdata = {r_lo, lo_hold};
        end
    end
endmodule

// File: rtl/segbus_unit.sv
module segbus_unit
    import segbus_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int LANE_W    = 8,
    localparam int PA_W     = OFS_W + SEG_SHIFT,
    localparam int DATA_W   = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [OFS_W-1:0]  reg_wr_val,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [OFS_W-1:0]  req_ea,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam logic [OFS_W-1:0] STEP1 = OFS_W'(1);
    localparam logic [OFS_W-1:0] STEP2 = OFS_W'(2);

    typedef struct packed {
        bus_st_e           st;
        logic [OFS_W-1:0]  cs;
        logic [OFS_W-1:0]  ds;
        logic [OFS_W-1:0]  ss;
        logic [OFS_W-1:0]  ip;
        logic [OFS_W-1:0]  sp;
        logic [PA_W-1:0]   addr;
        logic              odd;
        logic              word;
        logic              we;
        acc_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic [LANE_W-1:0] lo_hold;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } state_t;

    state_t            s_d, s_q;
    acc_kind_e         kind_in;
    logic [OFS_W-1:0]  sel_seg, sel_off;
    logic [PA_W-1:0]   phys_new;
    logic [1:0]        st_be;
    logic [DATA_W-1:0] st_wdata, st_rdata;
    logic [LANE_W-1:0] st_cap;
    logic              finish;

    seg_addr_gen #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
        .seg  (sel_seg),
        .off  (sel_off),
        .phys (phys_new)
    );

    lane_steer #(.LANE_W(LANE_W)) u_lanes (
        .start_odd   (s_q.odd),
        .word        (s_q.word),
        .second      (s_q.st == ST_SECOND),
        .wdata       (s_q.wdata),
        .bus_rdata   (mem_rdata),
        .lo_hold     (s_q.lo_hold),
        .be          (st_be),
        .bus_wdata   (st_wdata),
        .lo_capture  (st_cap),
        .final_rdata (st_rdata)
    );

    // Segment / offset choice for the incoming request
    always_comb begin
        kind_in = acc_kind_e'(req_kind);
        unique case (kind_in)
            K_FETCH: begin sel_seg = s_q.cs; sel_off = s_q.ip;         end
            K_DATA:  begin sel_seg = s_q.ds; sel_off = req_ea;         end
            K_PUSH:  begin sel_seg = s_q.ss; sel_off = s_q.sp - STEP2; end
            default: begin sel_seg = s_q.ss; sel_off = s_q.sp;         end
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        finish    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_FIRST;
                    s_d.addr  = phys_new;
                    s_d.odd   = phys_new[0];
                    s_d.word  = req_word || (kind_in == K_PUSH) || (kind_in == K_POP);
                    s_d.we    = ((kind_in == K_DATA) && req_write) || (kind_in == K_PUSH);
                    s_d.kind  = kind_in;
                    s_d.wdata = req_wdata;
                    if (kind_in == K_PUSH) s_d.sp = s_q.sp - STEP2;
                end else if (reg_wr_en) begin
                    unique case (reg_wr_sel)
                        SEL_CODE:  s_d.cs = reg_wr_val;
                        SEL_DATA:  s_d.ds = reg_wr_val;
                        SEL_STACK: s_d.ss = reg_wr_val;
                        SEL_IP:    s_d.ip = reg_wr_val;
                        SEL_SP:    s_d.sp = reg_wr_val;
                        default:   ;
                    endcase
                end
            end
            ST_FIRST: begin
                if (mem_ack) begin
                    if (s_q.word && s_q.odd) begin
                        s_d.st      = ST_SECOND;
                        s_d.addr    = s_q.addr + PA_W'(1);
                        s_d.lo_hold = st_cap;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            default: begin
                if (mem_ack) finish = 1'b1;
            end
        endcase

        if (finish) begin
            s_d.st    = ST_IDLE;
            s_d.rsp_v = 1'b1;
            s_d.rsp_d = s_q.we ? '0 : st_rdata;
            if (s_q.kind == K_FETCH) s_d.ip = s_q.ip + (s_q.word ? STEP2 : STEP1);
            if (s_q.kind == K_POP)   s_d.sp = s_q.sp + STEP2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.kind <= K_FETCH;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready  = (s_q.st == ST_IDLE);
        mem_req    = (s_q.st != ST_IDLE);
        mem_addr   = s_q.addr;
        mem_we     = s_q.we;
        mem_be     = st_be;
        mem_wdata  = st_wdata;
        resp_valid = s_q.rsp_v;
        resp_rdata = s_q.rsp_d;
    end
endmodule

// File: rtl/segbus_checker.sv
module segbus_checker #(
    parameter int PA_W   = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req,
    input logic [PA_W-1:0]   mem_addr,
    input logic              mem_we,
    input logic [1:0]        mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_we) && $stable(mem_wdata));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    a_r3_odd_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_addr[0] |-> mem_be == 2'b10);

    a_r3_even_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_addr[0] |-> mem_be[0]);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r8_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

bind segbus_unit segbus_checker #(.PA_W(PA_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/tb_segbus_unit.sv
module tb_segbus_unit;
    localparam logic [1:0] KF = 2'd0, KD = 2'd1, KPU = 2'd2, KPO = 2'd3;
    localparam logic [2:0] RCS = 3'd0, RDS = 3'd1, RSS = 3'd2, RIP = 3'd3, RSP = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_val = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_ea = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid;
    logic [15:0] resp_rdata;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    segbus_unit dut (.*);

    // Memory model and bus-cycle log
    logic [7:0]  mem [logic [19:0]];
    logic [19:0] lg_addr [8];
    logic [1:0]  lg_be [8];
    logic        lg_we [8];
    logic [15:0] lg_wd [8];
    int          nlog = 0;

    function automatic logic [7:0] rd_byte(input logic [19:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= {rd_byte({mem_addr[19:1], 1'b1}), rd_byte({mem_addr[19:1], 1'b0})};
            if (mem_we && mem_be[0]) mem[{mem_addr[19:1], 1'b0}] = mem_wdata[7:0];
            if (mem_we && mem_be[1]) mem[{mem_addr[19:1], 1'b1}] = mem_wdata[15:8];
            if (nlog < 8) begin
                lg_addr[nlog] = mem_addr;
                lg_be[nlog]   = mem_be;
                lg_we[nlog]   = mem_we;
                lg_wd[nlog]   = mem_wdata;
            end
            nlog = nlog + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_val = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic xfer(input logic [1:0] kind, input logic wr, input logic word,
                        input logic [15:0] ea, input logic [15:0] wd,
                        output logic [15:0] rd);
        int t;
        @(negedge clk);
        nlog = 0;
        req_valid = 1'b1; req_kind = kind; req_write = wr; req_word = word;
        req_ea = ea; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
        t = 0;
        while (!resp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R8 response arrives", {31'd0, resp_valid}, 32'd1);
        rd = resp_rdata;
        @(negedge clk);
        chk("R8 response is one cycle", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R9 no bus cycle after reset", {31'd0, mem_req}, 32'd0);
        chk("R8 no response after reset", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic t_addr_calc();
        logic [15:0] rd;
        wr_reg(RDS, 16'h1000);
        xfer(KD, 1'b0, 1'b0, 16'h0029, 16'h0, rd);
        chk("R1 address seg*16+off", {12'd0, lg_addr[0]}, 32'h10029);
        chk("R3 odd byte on upper lane", {30'd0, lg_be[0]}, 32'h2);
        chk("R3 odd byte read data", {16'd0, rd}, {24'd0, rd_byte(20'h10029)});
        wr_reg(RDS, 16'hFFFF);
        xfer(KD, 1'b0, 1'b0, 16'h0010, 16'h0, rd);
        chk("R1 wrap modulo 2^20", {12'd0, lg_addr[0]}, 32'h00000);
        chk("R3 even byte on low lane", {30'd0, lg_be[0]}, 32'h1);
    endtask

    task automatic t_even_word();
        logic [15:0] rd;
        wr_reg(RDS, 16'hA4FB);
        xfer(KD, 1'b1, 1'b1, 16'h4872, 16'hBEEF, rd);
        chk("R4 even word single cycle", nlog, 1);
        chk("R4 even word address", {12'd0, lg_addr[0]}, 32'hA9822);
        chk("R4 even word lanes", {30'd0, lg_be[0]}, 32'h3);
        chk("R8 write response zero", {16'd0, rd}, 32'h0);
        chk("R4 low byte at lower address", {24'd0, rd_byte(20'hA9822)}, 32'hEF);
        xfer(KD, 1'b0, 1'b1, 16'h4872, 16'h0, rd);
        chk("R4 even word read back", {16'd0, rd}, 32'hBEEF);
    endtask

    task automatic t_odd_word();
        logic [15:0] rd;
        xfer(KD, 1'b1, 1'b1, 16'h4873, 16'h1234, rd);
        chk("R5 odd word two cycles", nlog, 2);
        chk("R5 first cycle address", {12'd0, lg_addr[0]}, 32'hA9823);
        chk("R5 first cycle lanes", {30'd0, lg_be[0]}, 32'h2);
        chk("R5 first cycle low byte upper lane", {24'd0, lg_wd[0][15:8]}, 32'h34);
        chk("R5 second cycle address", {12'd0, lg_addr[1]}, 32'hA9824);
        chk("R5 second cycle lanes", {30'd0, lg_be[1]}, 32'h1);
        chk("R5 second cycle high byte low lane", {24'd0, lg_wd[1][7:0]}, 32'h12);
        xfer(KD, 1'b0, 1'b0, 16'h4874, 16'h0, rd);
        chk("R5 high byte stored at A+1", {16'd0, rd}, 32'h12);
        xfer(KD, 1'b0, 1'b1, 16'h4873, 16'h0, rd);
        chk("R5 odd word read reassembled", {16'd0, rd}, 32'h1234);
        chk("R5 odd word read two cycles", nlog, 2);
    endtask

    task automatic t_fetch();
        logic [15:0] rd;
        wr_reg(RCS, 16'h0400);
        wr_reg(RIP, 16'h0056);
        xfer(KF, 1'b0, 1'b0, 16'h7777, 16'h0, rd);
        chk("R2 fetch uses code seg and IP", {12'd0, lg_addr[0]}, 32'h04056);
        chk("R2 fetch byte data", {16'd0, rd}, {24'd0, rd_byte(20'h04056)});
        xfer(KF, 1'b0, 1'b1, 16'h0, 16'h0, rd);
        chk("R7 IP advanced by one", {12'd0, lg_addr[0]}, 32'h04057);
        chk("R5 fetch word data", {16'd0, rd},
            {16'd0, rd_byte(20'h04058), rd_byte(20'h04057)});
        xfer(KF, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        chk("R7 IP advanced by two", {12'd0, lg_addr[0]}, 32'h04059);
    endtask

    task automatic t_stack();
        logic [15:0] rd;
        wr_reg(RSS, 16'h0A00);
        wr_reg(RSP, 16'h0100);
        xfer(KPU, 1'b0, 1'b0, 16'h0, 16'hCAFE, rd);
        chk("R6 push pre-decrements SP", {12'd0, lg_addr[0]}, 32'h0A0FE);
        chk("R6 push is word write", {29'd0, lg_we[0], lg_be[0]}, 32'h7);
        xfer(KPO, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        chk("R6 pop reads at SP", {12'd0, lg_addr[0]}, 32'h0A0FE);
        chk("R6 pop data", {16'd0, rd}, 32'hCAFE);
        xfer(KPU, 1'b0, 1'b0, 16'h0, 16'h1111, rd);
        chk("R6 pop post-increments SP", {12'd0, lg_addr[0]}, 32'h0A0FE);
        wr_reg(RSP, 16'h0101);
        xfer(KPU, 1'b0, 1'b0, 16'h0, 16'hA1B2, rd);
        chk("R6 odd push split", nlog, 2);
        chk("R6 odd push address", {12'd0, lg_addr[0]}, 32'h0A0FF);
        xfer(KPO, 1'b0, 1'b0, 16'h0, 16'h0, rd);
        chk("R6 odd pop data", {16'd0, rd}, 32'hA1B2);
    endtask

    task automatic t_ignored_load();
        logic [15:0] rd;
        int t;
        wr_reg(RDS, 16'h3000);
        @(negedge clk);
        nlog = 0;
        req_valid = 1'b1; req_kind = KD; req_write = 1'b0; req_word = 1'b0; req_ea = 16'h0010;
        reg_wr_en = 1'b1; reg_wr_sel = RDS; reg_wr_val = 16'h5000;
        @(negedge clk);
        req_valid = 1'b0;
        reg_wr_sel = RDS; reg_wr_val = 16'h6000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        t = 0;
        while (!resp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        xfer(KD, 1'b0, 1'b0, 16'h0010, 16'h0, rd);
        chk("R10 loads ignored during request and busy", {12'd0, lg_addr[0]}, 32'h30010);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_calc();
        t_even_word();
        t_odd_word();
        t_fetch();
        t_stack();
        t_ignored_load();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule